// File: doc/BRIEF.md
# Host Command Frame Parser

This block sits behind a UART receiver and transmitter and handles a small host-to-device programming protocol. Bytes arriving from the receiver are dropped until a line break has been reported. After that the block looks for frames. A frame is a sync byte, a two-byte length, a one-byte checksum and a payload whose first byte is the command. The block checks each frame, decodes the command, updates its file and status state, and sends a short response frame back through the transmitter.

File-write commands do not go through a buffer. Each data byte is passed straight to a write port, together with the byte's offset inside the file that is currently open. The running file offset only moves forward when the frame's checksum turns out to be good. A frame that is retransmitted after a checksum error therefore lands on the same offsets again. The version word and the whole-image CRC verdict come from outside the block as inputs.

Top module: `host_frame_parser`

## Requirements
- R1: Until the first cycle with `brk_i` high, every received byte is accepted and discarded, and no response byte, write strobe or erase pulse is produced.
- R2: A frame is 0xAA, then a length L sent high byte first, then a checksum byte, then L-2 payload bytes. Payload byte 0 is the command. Any byte other than 0xAA seen while hunting for a frame is dropped.
- R3: If L is below 3 or above 256, the frame is abandoned and the parser hunts for the next 0xAA. No response is sent and the status is left as it was.
- R4: The checksum is the low 8 bits of the sum of the payload bytes. On a mismatch the frame produces no response and no state change, and the status becomes 0x02.
- R5: An accepted command is answered with 00 04 CC CC 00. A rejected command is answered with 00 04 (0x33+s) 33 s, where s is the new status. Status codes: 0x00 ok, 0x01 unknown command, 0x03 bad argument, 0x04 no file open, 0x05 image CRC failure. Ping (0x20) is always accepted.
- R6: Get-status (0x23) answers 00 03 s s, where s is the status left by the previous command. Get-status does not change the status itself.
- R7: Get-version (0x2F) answers 00 0E c v3 v2 v1 v0 followed by eight zero bytes. v3..v0 are `version_i` sent most significant byte first, and c is their 8-bit sum.
- R8: Open (0x21) needs L = 0x13. The file type is payload bytes 5..8, most significant first, and must be between 4 and 7. On success the file is marked open and its offset is cleared. Otherwise status 0x03 is returned and the file state is unchanged.
- R9: Write-to-flash (0x24) and write-to-RAM (0x26) with a file open emit one registered strobe per data byte. The strobe carries the byte, a RAM/flash select, and offset = file offset + byte index. The file offset advances by the data count only if the checksum is good. With no file open, no strobe is produced and status 0x04 is returned.
- R10: Close (0x22) needs L = 7 (status 0x03 otherwise) and an open file (status 0x04 otherwise). It closes the file, and it is accepted only if `crc_ok_i` is high; if not, status 0x05 is returned.
- R11: Erase (0x28) is accepted and gives a one-cycle `erase_o` pulse. Any command not in the set gets status 0x01.
- R12: While a response is being sent, `rx_ready_o` is low. A stalled response byte keeps its value until `tx_ready_i` takes it.
- R13: A break outside a response abandons any partial frame, and the parser returns to hunting for 0xAA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brk_i | input | 1 | Line break detected by the UART receiver |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_ready_o | output | 1 | Parser can take a byte |
| tx_data_o | output | 8 | Response byte |
| tx_valid_o | output | 1 | Response byte valid |
| tx_ready_i | input | 1 | Transmitter takes the byte |
| wr_valid_o | output | 1 | Write strobe for one data byte |
| wr_ram_o | output | 1 | 1: byte goes to RAM, 0: byte goes to flash |
| wr_data_o | output | 8 | Data byte to write |
| wr_off_o | output | OFF_W | Byte offset within the open file |
| erase_o | output | 1 | One-cycle erase request |
| crc_ok_i | input | 1 | Whole-image CRC matched |
| version_i | input | 32 | Version word returned by get-version |

## Verification
The assertions assume that `brk_i` is only raised between frames or part-way through one, and never relied on while a response is being sent. They also assume that the transmitter may stall for any number of cycles, and that a write frame's data bytes arrive on cycles that may or may not be back to back. The bench drives received bytes only while `rx_ready_o` is high, with an idle cycle after each byte. It throttles `tx_ready_i` with a fixed repeating pattern, so response stalls are always present. It raises a break only before the first frame and once inside a partial frame.

// File: rtl/host_frame_parser.sv
module host_frame_parser #(
  parameter int OFF_W   = 24,
  parameter int MAX_LEN = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brk_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_valid_i,
  output logic             rx_ready_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic             wr_valid_o,
  output logic             wr_ram_o,
  output logic [7:0]       wr_data_o,
  output logic [OFF_W-1:0] wr_off_o,
  output logic             erase_o,
  input  logic             crc_ok_i,
  input  logic [31:0]      version_i
);
  localparam logic [7:0]  SYNC    = 8'hAA;
  localparam logic [15:0] LEN_MAX = 16'(MAX_LEN);
  localparam logic [7:0]  ST_OK = 8'h00, ST_UNK = 8'h01, ST_CSUM = 8'h02,
                          ST_ARG = 8'h03, ST_NOFILE = 8'h04, ST_CRC = 8'h05;

  typedef enum logic [2:0] {S_WAIT, S_SYNC, S_LENH, S_LENL, S_CSUM, S_PAY, S_RESP} st_t;
  typedef enum logic [1:0] {R_ACK, R_NACK, R_STAT, R_VER} rk_t;

  st_t             st;
  rk_t             rk, d_rk;
  logic [7:0]      lenh, plen, idx, cmd, sum, csum, status, d_status, tbyte;
  logic [31:0]     ftype;
  logic            fopen, d_open, d_resp, d_erase;
  logic [OFF_W-1:0] foff, d_foff;
  logic [3:0]      tidx, tlast;

  wire        take   = rx_valid_i && rx_ready_o;
  wire [15:0] len_w  = {lenh, rx_data_i};
  wire        len_ok = (len_w >= 16'd3) && (len_w <= LEN_MAX);
  wire [7:0]  cmd_now = (idx == 8'd0) ? rx_data_i : cmd;
  wire [7:0]  sum_nx = sum + rx_data_i;
  wire        last   = (idx == plen - 8'd1);
  wire        is_wr  = (cmd == 8'h24) || (cmd == 8'h26);
  wire [7:0]  ver_cs = version_i[31:24] + version_i[23:16] + version_i[15:8] + version_i[7:0];

  assign rx_ready_o = (st != S_RESP);
  assign tx_valid_o = (st == S_RESP);
  assign tx_data_o  = tbyte;

  always_comb begin
    d_resp   = 1'b1;
    d_rk     = R_ACK;
    d_status = ST_OK;
    d_open   = fopen;
    d_foff   = foff;
    d_erase  = 1'b0;
    if (sum_nx != csum) begin
      d_resp   = 1'b0;
      d_status = ST_CSUM;
    end else begin
      case (cmd_now)
        8'h20: ;
        8'h21: begin
          if (plen == 8'd17 && ftype >= 32'd4 && ftype <= 32'd7) begin
            d_open = 1'b1;
            d_foff = '0;
          end else begin
            d_rk = R_NACK; d_status = ST_ARG;
          end
        end
        8'h22: begin
          if (plen != 8'd5) begin
            d_rk = R_NACK; d_status = ST_ARG;
          end else if (!fopen) begin
            d_rk = R_NACK; d_status = ST_NOFILE;
          end else begin
            d_open = 1'b0;
            if (!crc_ok_i) begin
              d_rk = R_NACK; d_status = ST_CRC;
            end
          end
        end
        8'h23: begin
          d_rk = R_STAT; d_status = status;
        end
        8'h24, 8'h26: begin
          if (!fopen) begin
            d_rk = R_NACK; d_status = ST_NOFILE;
          end else begin
            d_foff = foff + OFF_W'(plen - 8'd1);
          end
        end
        8'h28: d_erase = 1'b1;
        8'h2F: d_rk = R_VER;
        default: begin
          d_rk = R_NACK; d_status = ST_UNK;
        end
      endcase
    end
  end

  always_comb begin
    tbyte = 8'h00;
    tlast = 4'd4;
    case (rk)
      R_ACK: case (tidx)
        4'd1: tbyte = 8'h04;
        4'd2, 4'd3: tbyte = 8'hCC;
        default: tbyte = 8'h00;
      endcase
      R_NACK: case (tidx)
        4'd1: tbyte = 8'h04;
        4'd2: tbyte = 8'h33 + status;
        4'd3: tbyte = 8'h33;
        4'd4: tbyte = status;
        default: tbyte = 8'h00;
      endcase
      R_STAT: begin
        tlast = 4'd3;
        case (tidx)
          4'd1: tbyte = 8'h03;
          4'd2, 4'd3: tbyte = status;
          default: tbyte = 8'h00;
        endcase
      end
      R_VER: begin
        tlast = 4'd14;
        case (tidx)
          4'd1: tbyte = 8'h0E;
          4'd2: tbyte = ver_cs;
          4'd3: tbyte = version_i[31:24];
          4'd4: tbyte = version_i[23:16];
          4'd5: tbyte = version_i[15:8];
          4'd6: tbyte = version_i[7:0];
          default: tbyte = 8'h00;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_WAIT; rk <= R_ACK;
      lenh <= '0; plen <= '0; idx <= '0; cmd <= '0; sum <= '0; csum <= '0;
      ftype <= '0; fopen <= 1'b0; foff <= '0; status <= ST_OK; tidx <= '0;
      wr_valid_o <= 1'b0; wr_ram_o <= 1'b0; wr_data_o <= '0; wr_off_o <= '0;
      erase_o <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      erase_o    <= 1'b0;
      if (brk_i && st != S_RESP) begin
        st <= S_SYNC;
      end else begin
        case (st)
          S_WAIT: ;
          S_SYNC: if (take && rx_data_i == SYNC) st <= S_LENH;
          S_LENH: if (take) begin
            lenh <= rx_data_i;
            st   <= S_LENL;
          end
          S_LENL: if (take) begin
            plen <= 8'(len_w - 16'd2);
            st   <= len_ok ? S_CSUM : S_SYNC;
          end
          S_CSUM: if (take) begin
            csum <= rx_data_i;
            sum  <= '0;
            idx  <= '0;
            st   <= S_PAY;
          end
          S_PAY: if (take) begin
            idx <= idx + 8'd1;
            sum <= sum_nx;
            if (idx == 8'd0) cmd <= rx_data_i;
            if (idx >= 8'd5 && idx <= 8'd8) ftype <= {ftype[23:0], rx_data_i};
            if (idx != 8'd0 && is_wr && fopen) begin
              wr_valid_o <= 1'b1;
              wr_ram_o   <= (cmd == 8'h26);
              wr_data_o  <= rx_data_i;
              wr_off_o   <= foff + OFF_W'(idx - 8'd1);
            end
            if (last) begin
              status  <= d_status;
              fopen   <= d_open;
              foff    <= d_foff;
              erase_o <= d_erase;
              rk      <= d_rk;
              tidx    <= '0;
              st      <= d_resp ? S_RESP : S_SYNC;
            end
          end
          S_RESP: if (tx_ready_i) begin
            if (tidx == tlast) begin
              tidx <= '0;
              st   <= S_SYNC;
            end else begin
              tidx <= tidx + 4'd1;
            end
          end
          default: st <= S_SYNC;
        endcase
      end
    end
  end
endmodule

// File: rtl/host_frame_parser_chk.sv
module host_frame_parser_chk #(
  parameter int OFF_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             brk_i,
  input logic [7:0]       tx_data_o,
  input logic             tx_valid_o,
  input logic             tx_ready_i,
  input logic             wr_valid_o,
  input logic [OFF_W-1:0] wr_off_o,
  input logic             erase_o
);
  logic seen_brk;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_brk <= 1'b0;
    else if (brk_i) seen_brk <= 1'b1;

  assert_gated_until_break_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_brk |-> (!tx_valid_o && !wr_valid_o && !erase_o));

  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  assert_wr_offset_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && $past(wr_valid_o)) |-> (wr_off_o == $past(wr_off_o) + OFF_W'(1)));

  assert_erase_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_o |=> !erase_o);
endmodule

bind host_frame_parser host_frame_parser_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .brk_i(brk_i), .tx_data_o(tx_data_o),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .wr_valid_o(wr_valid_o),
  .wr_off_o(wr_off_o), .erase_o(erase_o)
);

// File: tb/host_frame_parser_bench.sv
module host_frame_parser_bench;
  localparam int OFF_W = 24;

  logic clk = 1'b0, rst_n = 1'b0, brk = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0, rx_ready, tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data, wr_data;
  logic wr_valid, wr_ram, erase, crc_ok = 1'b1;
  logic [OFF_W-1:0] wr_off;
  logic [31:0] version = 32'h12345678;

  always #5 clk = ~clk;

  host_frame_parser #(.OFF_W(OFF_W)) u_host_frame_parser (
    .clk(clk), .rst_n(rst_n), .brk_i(brk), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_ready_o(rx_ready), .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .wr_valid_o(wr_valid), .wr_ram_o(wr_ram), .wr_data_o(wr_data), .wr_off_o(wr_off),
    .erase_o(erase), .crc_ok_i(crc_ok), .version_i(version)
  );

  int checks = 0, fails = 0, cyc = 0, ers = 0;
  bit done = 1'b0;
  logic [7:0] got[$], exq[$], pl[$];
  logic [7:0] wd[$];
  logic [OFF_W-1:0] wo[$];
  logic wram[$];

  always @(negedge clk) begin
    cyc++;
    tx_ready = (cyc % 3) != 0;
    if (tx_valid && tx_ready) got.push_back(tx_data);
    if (wr_valid) begin wd.push_back(wr_data); wo.push_back(wr_off); wram.push_back(wr_ram); end
    if (erase) ers++;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic put(input logic [7:0] b);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_brk();
    brk = 1'b1; @(negedge clk); brk = 1'b0; @(negedge clk);
  endtask

  task automatic send(input bit bad);
    logic [15:0] len; logic [7:0] cs;
    len = 16'(pl.size() + 2); cs = 8'h00;
    foreach (pl[i]) cs += pl[i];
    if (bad) cs = cs ^ 8'hFF;
    put(8'hAA); put(len[15:8]); put(len[7:0]); put(cs);
    foreach (pl[i]) put(pl[i]);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(input string req);
    bit ok; int a, e;
    ok = (got.size() == exq.size());
    a = got.size(); e = exq.size();
    if (ok) foreach (exq[i]) if (got[i] !== exq[i]) begin ok = 0; a = got[i]; e = exq[i]; break; end
    check(ok, req, "response", a, e);
    got.delete();
  endtask

  task automatic set_ack();           exq = '{8'h00, 8'h04, 8'hCC, 8'hCC, 8'h00}; endtask
  task automatic set_nack(input logic [7:0] s); exq = '{8'h00, 8'h04, 8'(8'h33 + s), 8'h33, s}; endtask
  task automatic set_stat(input logic [7:0] s); exq = '{8'h00, 8'h03, s, s}; endtask
  task automatic cmd1(input logic [7:0] c); pl.delete(); pl.push_back(c); endtask

  task automatic open_pl(input logic [31:0] t);
    pl = '{8'h21, 8'h00, 8'h00, 8'h10, 8'h00, t[31:24], t[23:16], t[15:8], t[7:0],
           8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
  endtask
  task automatic close_pl(); pl = '{8'h22, 8'h00, 8'h00, 8'h00, 8'h05}; endtask

  task automatic write_frame(input bit ram, input int n, input bit bad, input int base, input string req);
    bit ok;
    pl.delete(); pl.push_back(ram ? 8'h26 : 8'h24);
    for (int i = 0; i < n; i++) pl.push_back(8'((i * 7 + n) & 8'hFF));
    wd.delete(); wo.delete(); wram.delete();
    send(bad);
    ok = (wd.size() == n);
    for (int i = 0; i < n && ok; i++)
      if (wd[i] !== pl[i+1] || wo[i] !== OFF_W'(base + i) || wram[i] !== ram) ok = 0;
    check(ok, req, $sformatf("write strobes n=%0d ram=%0d", n, ram), wd.size(), n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    logic [7:0] vs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_valid && !wr_valid && !erase && rx_ready, "R12", "reset outputs",
          {tx_valid, wr_valid, erase, rx_ready}, 4'b0001);

    // R1: traffic before any break is swallowed
    cmd1(8'h20); send(0); repeat (10) @(negedge clk);
    exq.delete(); compare("R1");
    cmd1(8'h28); send(0);
    check(ers == 0, "R1", "erase before break", ers, 0);

    pulse_brk();

    // R2 R5: ping acknowledged; check rx blocked during response (R12)
    cmd1(8'h20);
    put(8'hAA); put(8'h00); put(8'h03); put(8'h20); put(8'h20);
    check(!rx_ready && tx_valid, "R12", "rx blocked while responding", rx_ready, 0);
    while (!rx_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    set_ack(); compare("R5");

    // noise before sync is dropped
    put(8'h55); put(8'h00); cmd1(8'h20); send(0); set_ack(); compare("R2");

    cmd1(8'h23); send(0); set_stat(8'h00); compare("R6");

    // R4 checksum error
    cmd1(8'h20); send(1); exq.delete(); compare("R4");
    cmd1(8'h23); send(0); set_stat(8'h02); compare("R4");
    cmd1(8'h23); send(0); set_stat(8'h02); compare("R6");

    // R3 bad lengths
    put(8'hAA); put(8'h00); put(8'h02);
    cmd1(8'h20); send(0); set_ack(); compare("R3");
    put(8'hAA); put(8'h01); put(8'h01);
    cmd1(8'h20); send(0); set_ack(); compare("R3");

    // R9 write without open
    wd.delete();
    pl = '{8'h24, 8'h11, 8'h22}; send(0); set_nack(8'h04); compare("R9");
    check(wd.size() == 0, "R9", "no strobes when closed", wd.size(), 0);

    // R11 unknown, erase
    cmd1(8'h55); send(0); set_nack(8'h01); compare("R11");
    cmd1(8'h28); send(0); set_ack(); compare("R11");
    check(ers == 1, "R11", "erase pulse count", ers, 1);

    // R8 file type sweep
    for (int t = 0; t < 10; t++) begin
      open_pl(32'(t)); send(0);
      if (t >= 4 && t <= 7) set_ack(); else set_nack(8'h03);
      compare("R8");
    end
    pl = '{8'h21, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h05};
    send(0); set_nack(8'h03); compare("R8");

    // R9 write sweep, offsets run on across frames, 256-byte frame at the limit (R3)
    base = 0;
    foreach (pl[i]) ;
    begin
      int ns[6] = '{0, 1, 2, 5, 31, 253};
      for (int k = 0; k < 6; k++) begin
        write_frame(k[0], ns[k], 0, base, "R9");
        set_ack(); compare("R9");
        base += ns[k];
      end
    end

    // R9 R4: bad-checksum write strobes but does not advance
    write_frame(1'b0, 4, 1, base, "R9");
    exq.delete(); compare("R4");
    write_frame(1'b1, 3, 0, base, "R9");
    set_ack(); compare("R9");

    // R7 version
    vs = version[31:24] + version[23:16] + version[15:8] + version[7:0];
    cmd1(8'h2F); send(0);
    exq = '{8'h00, 8'h0E, vs, version[31:24], version[23:16], version[15:8], version[7:0],
           8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    compare("R7");

    // R10 close
    pl = '{8'h22, 8'h00, 8'h05}; send(0); set_nack(8'h03); compare("R10");
    crc_ok = 1'b0; close_pl(); send(0); set_nack(8'h05); compare("R10");
    crc_ok = 1'b1;
    pl = '{8'h24, 8'h01}; send(0); set_nack(8'h04); compare("R10");
    open_pl(32'd4); send(0); set_ack(); compare("R8");
    write_frame(1'b0, 2, 0, 0, "R8");
    set_ack(); compare("R9");
    close_pl(); send(0); set_ack(); compare("R10");
    close_pl(); send(0); set_nack(8'h04); compare("R10");

    // R13 break mid-frame
    put(8'hAA); put(8'h00); put(8'h05); put(8'h00); put(8'h21);
    pulse_brk();
    cmd1(8'h20); send(0); set_ack(); compare("R13");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule